// File: doc/BRIEF.md
# Memory Region Address Decoder

This block sits between a processor's 24-bit byte-address bus and the targets behind it. It compares each address against a fixed map and routes the access to one of three targets: nonvolatile program storage (flash), working RAM, or the peripheral register space. For each target it produces a select strobe and a target-relative offset. It also returns the matching target's read byte through one multiplexer.

The display frame buffer does not have its own select. It is a window at the top of RAM, and a separate flag marks any access that lands inside it, so a display path can watch writes to it. Addresses that fall in holes of the map reach no target. A write there is discarded. A read there returns a byte taken from a free-running pseudo-random generator, which advances only on such reads.

Top module: `addr_router`

## Requirements
- R1: An access (rd_en or wr_en high) to 0x000000..0x3FFFFF raises flash_sel. flash_off equals the address.
- R2: An access to 0xD00000..0xD657FF raises ram_sel. ram_off equals the address minus 0xD00000.
- R3: fb_hit is high only during an access to 0xD40000..0xD657FF (320x240 pixels, 2 bytes each). Whenever fb_hit is high, ram_sel is also high.
- R4: An access to 0xE00000..0xFFFFFF raises io_sel. io_off equals the address minus 0xE00000.
- R5: The holes 0x400000..0xCFFFFF and 0xD65800..0xDFFFFF raise no select. A read in a hole returns the filler byte on rdata.
- R6: The filler is a 16-bit Galois LFSR. Each step shifts the state right by one; if the bit shifted out was 1, the state is then XORed with 0xB400. Reset loads the seed parameter. The filler byte is the low 8 bits of the state. The state steps once for each clock cycle that holds a read in a hole, and holds in every other cycle.
- R7: A write in a hole is dropped: no select rises and tgt_wr stays low. A write to a mapped region raises tgt_wr, and tgt_wdata carries wdata.
- R8: At most one select is high in any cycle. With both strobes low, no select is high and fb_hit is low.
- R9: During a read, rdata equals the selected target's read byte (flash_rdata, ram_rdata or io_rdata). With rd_en low, rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 24 | Byte address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data from the processor |
| flash_rdata | input | 8 | Read data from flash |
| ram_rdata | input | 8 | Read data from RAM |
| io_rdata | input | 8 | Read data from the peripheral space |
| flash_sel | output | 1 | Flash select |
| ram_sel | output | 1 | RAM select |
| io_sel | output | 1 | Peripheral select |
| fb_hit | output | 1 | Access lies inside the frame buffer window |
| tgt_wr | output | 1 | Write forwarded to a mapped target |
| tgt_wdata | output | 8 | Write data to the targets |
| flash_off | output | 22 | Offset within flash |
| ram_off | output | 19 | Offset within RAM |
| io_off | output | 21 | Offset within the peripheral space |
| rdata | output | 8 | Read data to the processor |

## Verification
The bench builds the block with the default map and data width. It overrides the filler seed with 0x1D2B, so the expected filler bytes come from a seed that differs from the default. With the full 24-bit map in place, the first and last byte of every region and of both holes can be reached directly. This covers the RAM/frame-buffer edge and the address just past the end of RAM. Reads in holes are interleaved with mapped reads and with writes to holes, which shows that the generator steps only on reads in holes.

// File: rtl/addr_router_pkg.sv
package addr_router_pkg;

    localparam int MAP_ADDR_W = 24;

    localparam logic [MAP_ADDR_W-1:0] FLASH_BASE = 24'h000000;
    localparam logic [MAP_ADDR_W-1:0] FLASH_LAST = 24'h3FFFFF;
    localparam logic [MAP_ADDR_W-1:0] RAM_BASE   = 24'hD00000;
    localparam logic [MAP_ADDR_W-1:0] RAM_LAST   = 24'hD657FF;
    localparam logic [MAP_ADDR_W-1:0] FB_BASE    = 24'hD40000;
    localparam logic [MAP_ADDR_W-1:0] IO_BASE    = 24'hE00000;
    localparam logic [MAP_ADDR_W-1:0] IO_LAST    = 24'hFFFFFF;

    function automatic int span_bits(logic [MAP_ADDR_W-1:0] base,
                                     logic [MAP_ADDR_W-1:0] last);
        return $clog2(int'(last - base) + 1);
    endfunction

    typedef enum logic [1:0] {
        RGN_NONE  = 2'd0,
        RGN_FLASH = 2'd1,
        RGN_RAM   = 2'd2,
        RGN_IO    = 2'd3
    } region_e;

    typedef struct packed {
        region_e region;
        logic    fb;
    } route_t;

endpackage

// File: rtl/range_match.sv
module range_match #(
    parameter int                ADDR_W = 24,
    parameter logic [ADDR_W-1:0] BASE   = '0,
    parameter logic [ADDR_W-1:0] LAST   = '1,
    parameter int                OFF_W  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [OFF_W-1:0]  off
);
    localparam logic [ADDR_W-1:0] TOP     = '1;
    localparam logic [OFF_W-1:0]  BASE_LO = BASE[OFF_W-1:0];

    generate
        if (BASE == '0 && LAST == TOP) begin : g_all
            assign hit = 1'b1;
        end else if (BASE == '0) begin : g_low
            assign hit = (addr <= LAST);
        end else if (LAST == TOP) begin : g_high
            assign hit = (addr >= BASE);
        end else begin : g_mid
            assign hit = (addr >= BASE) && (addr <= LAST);
        end
    endgenerate

    // Within the window the low bits alone give the exact distance.
    assign off = addr[OFF_W-1:0] - BASE_LO;
endmodule

// File: rtl/filler_lfsr.sv
module filler_lfsr #(
    parameter int               W     = 16,
    parameter logic [W-1:0]     MASK  = 16'hB400,
    parameter logic [W-1:0]     SEED  = 16'hACE1,
    parameter int               OUT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [OUT_W-1:0] fill
);
    logic [W-1:0] state;
    logic [W-1:0] nxt;

    always_comb begin
        nxt = state >> 1;
        if (state[0]) nxt = nxt ^ MASK;
    end

    always_ff @(posedge clk) begin
        if (rst)       state <= SEED;
        else if (step) state <= nxt;
    end

    assign fill = state[OUT_W-1:0];

    a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(fill));
    a_r6_never_zero: assert property (@(posedge clk) disable iff (rst)
        state != '0);
endmodule

// File: rtl/rdata_mux.sv
module rdata_mux
    import addr_router_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  region_e           region,
    input  logic [DATA_W-1:0] flash_rdata,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic [DATA_W-1:0] io_rdata,
    input  logic [DATA_W-1:0] fill,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (region)
                RGN_FLASH: rdata = flash_rdata;
                RGN_RAM:   rdata = ram_rdata;
                RGN_IO:    rdata = io_rdata;
                default:   rdata = fill;
            endcase
        end
    end

    a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> rdata == '0);
endmodule

// File: rtl/addr_router.sv
module addr_router
    import addr_router_pkg::*;
#(
    parameter int                LFSR_W    = 16,
    parameter logic [LFSR_W-1:0] LFSR_MASK = 16'hB400,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
    parameter int                DATA_W    = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [MAP_ADDR_W-1:0]    addr,
    input  logic                     rd_en,
    input  logic                     wr_en,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [DATA_W-1:0]        flash_rdata,
    input  logic [DATA_W-1:0]        ram_rdata,
    input  logic [DATA_W-1:0]        io_rdata,
    output logic                     flash_sel,
    output logic                     ram_sel,
    output logic                     io_sel,
    output logic                     fb_hit,
    output logic                     tgt_wr,
    output logic [DATA_W-1:0]        tgt_wdata,
    output logic [span_bits(FLASH_BASE, FLASH_LAST)-1:0] flash_off,
    output logic [span_bits(RAM_BASE, RAM_LAST)-1:0]     ram_off,
    output logic [span_bits(IO_BASE, IO_LAST)-1:0]       io_off,
    output logic [DATA_W-1:0]        rdata
);
    localparam int FLASH_OFF_W = span_bits(FLASH_BASE, FLASH_LAST);
    localparam int RAM_OFF_W   = span_bits(RAM_BASE, RAM_LAST);
    localparam int IO_OFF_W    = span_bits(IO_BASE, IO_LAST);

    logic        hit_flash, hit_ram, hit_io;
    logic        access;
    route_t      route;
    logic [DATA_W-1:0] fill;

    range_match #(.ADDR_W(MAP_ADDR_W), .BASE(FLASH_BASE), .LAST(FLASH_LAST),
                  .OFF_W(FLASH_OFF_W))
        u_flash_rng (.addr(addr), .hit(hit_flash), .off(flash_off));

    range_match #(.ADDR_W(MAP_ADDR_W), .BASE(RAM_BASE), .LAST(RAM_LAST),
                  .OFF_W(RAM_OFF_W))
        u_ram_rng (.addr(addr), .hit(hit_ram), .off(ram_off));

    range_match #(.ADDR_W(MAP_ADDR_W), .BASE(IO_BASE), .LAST(IO_LAST),
                  .OFF_W(IO_OFF_W))
        u_io_rng (.addr(addr), .hit(hit_io), .off(io_off));

    assign access = rd_en | wr_en;

    // The frame buffer window shares its upper bound with RAM.
    always_comb begin
        route.region = RGN_NONE;
        if (hit_flash)    route.region = RGN_FLASH;
        else if (hit_ram) route.region = RGN_RAM;
        else if (hit_io)  route.region = RGN_IO;
        route.fb = hit_ram && (addr >= FB_BASE);
    end

    assign flash_sel = access && (route.region == RGN_FLASH);
    assign ram_sel   = access && (route.region == RGN_RAM);
    assign io_sel    = access && (route.region == RGN_IO);
    assign fb_hit    = access && route.fb;
    assign tgt_wr    = wr_en && (route.region != RGN_NONE);
    assign tgt_wdata = wdata;

    filler_lfsr #(.W(LFSR_W), .MASK(LFSR_MASK), .SEED(LFSR_SEED), .OUT_W(DATA_W))
        u_filler (.clk(clk), .rst(rst),
                  .step(rd_en && (route.region == RGN_NONE)),
                  .fill(fill));

    rdata_mux #(.DATA_W(DATA_W))
        u_rmux (.clk(clk), .rst(rst), .rd_en(rd_en), .region(route.region),
                .flash_rdata(flash_rdata), .ram_rdata(ram_rdata),
                .io_rdata(io_rdata), .fill(fill), .rdata(rdata));

    a_r8_one_select: assert property (@(posedge clk) disable iff (rst)
        $onehot0({flash_sel, ram_sel, io_sel}));
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !access |-> !(flash_sel || ram_sel || io_sel || fb_hit));
    a_r3_fb_in_ram: assert property (@(posedge clk) disable iff (rst)
        fb_hit |-> ram_sel);
    a_r7_drop_hole_write: assert property (@(posedge clk) disable iff (rst)
        tgt_wr |-> (flash_sel || ram_sel || io_sel));
endmodule

// File: tb/addr_router_bench.sv
module addr_router_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] addr = '0;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  flash_rdata = 8'h11, ram_rdata = 8'h22, io_rdata = 8'h33;
    logic        flash_sel, ram_sel, io_sel, fb_hit, tgt_wr;
    logic [7:0]  tgt_wdata, rdata;
    logic [21:0] flash_off;
    logic [18:0] ram_off;
    logic [20:0] io_off;

    int checks = 0;
    int errors = 0;
    logic [15:0] model = 16'h1D2B;

    always #2 clk = ~clk;

    addr_router #(.LFSR_SEED(16'h1D2B)) u_addr_router (
        .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .flash_rdata(flash_rdata), .ram_rdata(ram_rdata),
        .io_rdata(io_rdata), .flash_sel(flash_sel), .ram_sel(ram_sel),
        .io_sel(io_sel), .fb_hit(fb_hit), .tgt_wr(tgt_wr), .tgt_wdata(tgt_wdata),
        .flash_off(flash_off), .ram_off(ram_off), .io_off(io_off), .rdata(rdata));

    function automatic logic [15:0] lfsr_next(logic [15:0] s);
        logic [15:0] n = s >> 1;
        if (s[0]) n = n ^ 16'hB400;
        return n;
    endfunction

    // 0 hole, 1 flash, 2 ram, 3 io
    function automatic int exp_region(logic [23:0] a);
        if (a <= 24'h3FFFFF) return 1;
        if (a >= 24'hD00000 && a <= 24'hD657FF) return 2;
        if (a >= 24'hE00000) return 3;
        return 0;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic access(logic [23:0] a, logic rd, logic wr, logic [7:0] wd);
        int rg;
        logic acc;
        logic [7:0] er;
        @(negedge clk);
        addr = a; rd_en = rd; wr_en = wr; wdata = wd;
        #1;
        rg  = exp_region(a);
        acc = rd | wr;
        chk("R8 flash_sel", {31'd0, flash_sel}, {31'd0, acc && rg == 1});
        chk("R8 ram_sel",   {31'd0, ram_sel},   {31'd0, acc && rg == 2});
        chk("R8 io_sel",    {31'd0, io_sel},    {31'd0, acc && rg == 3});
        chk("R3 fb_hit", {31'd0, fb_hit},
            {31'd0, acc && a >= 24'hD40000 && a <= 24'hD657FF});
        chk("R7 tgt_wr", {31'd0, tgt_wr}, {31'd0, wr && rg != 0});
        if (wr) chk("R7 tgt_wdata", {24'd0, tgt_wdata}, {24'd0, wd});
        if (rg == 1) chk("R1 flash_off", {10'd0, flash_off}, {8'd0, a});
        if (rg == 2) chk("R2 ram_off", {13'd0, ram_off}, {8'd0, a - 24'hD00000});
        if (rg == 4'd3) chk("R4 io_off", {11'd0, io_off}, {8'd0, a - 24'hE00000});
        case (rg)
            1: er = flash_rdata;
            2: er = ram_rdata;
            3: er = io_rdata;
            default: er = model[7:0];
        endcase
        if (!rd) er = 8'h00;
        if (rg == 0) chk("R5 R6 filler rdata", {24'd0, rdata}, {24'd0, er});
        else         chk("R9 rdata", {24'd0, rdata}, {24'd0, er});
        if (rd && rg == 0) model = lfsr_next(model);
    endtask

    task automatic idle();
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0; addr = 24'hD40000;
        #1;
        chk("R8 idle no select", {29'd0, flash_sel, ram_sel, io_sel}, 32'd0);
        chk("R8 idle fb_hit", {31'd0, fb_hit}, 32'd0);
        chk("R9 idle rdata", {24'd0, rdata}, 32'd0);
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        idle();
    endtask

    task automatic t_flash();
        access(24'h000000, 1, 0, 8'h00);
        access(24'h3FFFFF, 1, 0, 8'h00);
        access(24'h12345A, 0, 1, 8'hA5);   // R1 write
    endtask

    task automatic t_ram_fb();
        access(24'hD00000, 1, 0, 8'h00);   // R2 low edge
        access(24'hD3FFFF, 1, 0, 8'h00);   // R3 just below window
        access(24'hD40000, 0, 1, 8'h5C);   // R3 window start
        access(24'hD657FF, 1, 0, 8'h00);   // R3 window end
    endtask

    task automatic t_io();
        access(24'hE00000, 1, 0, 8'h00);
        access(24'hFFFFFF, 0, 1, 8'h77);   // R4 top
    endtask

    task automatic t_holes();
        access(24'h400000, 1, 0, 8'h00);   // R5 low hole start
        access(24'hCFFFFF, 1, 0, 8'h00);
        access(24'hD65800, 1, 0, 8'h00);   // R5 past RAM end
        access(24'hDFFFFF, 1, 0, 8'h00);
        for (int i = 0; i < 6; i++) access(24'h800000 + 24'(i), 1, 0, 8'h00);
    endtask

    task automatic t_hold();
        access(24'h500000, 0, 1, 8'hEE);   // R7 dropped, R6 no step
        access(24'hD70000, 0, 1, 8'hEE);
        access(24'h000010, 1, 0, 8'h00);   // R6 mapped read: no step
        idle();
        access(24'h600000, 1, 0, 8'h00);   // R6 continues where it stopped
        access(24'h600001, 1, 0, 8'h00);
    endtask

    initial begin
        t_reset();
        t_flash();
        t_ram_fb();
        t_io();
        t_holes();
        t_hold();
        idle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule